// File: doc/BRIEF.md
# Hardware Write Inhibit Gate

This block sits between the raw write-strobe pins of a non-volatile memory and its write engine. It decides, edge by edge, whether a write attempt may go ahead. A write attempt is a window in which chip select and write enable are both held low. The gate passes an attempt on only if three conditions hold at the edge where it is accepted: the attempt has lasted long enough to rule out a glitch, output enable is not asserted, and the supply has been good for long enough after power-up.

The supply-good flag is the block's only link to the analog side. An external comparator drives it, and every input is taken to be synchronous to `clk`. A rising supply flag starts a hold-off counter of `HOLDOFF_CYCLES` clock edges. The default is sized for about 5 ms at 100 MHz. A falling flag clears the counter at once. The strobe filter counts how many consecutive edges the strobe pair has been sampled low, and accepts the attempt on the `GLITCH_CYCLES`-th such edge. Each attempt is judged exactly once. An attempt that is blocked at that edge stays blocked even if conditions improve later while the pins remain low. The write engine then sees a one-cycle start pulse and a level that stays up for the rest of the qualified window. A blocked attempt drives neither of them.

Top module: `write_inhibit_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `wr_fire` and `wr_hold` are both 0.
- R2: A write attempt exists only while `cs_n` and `we_n` are both 0. When the attempt is sampled low on its `GLITCH_CYCLES`-th consecutive rising edge and the gate is open at that edge, `wr_fire` is 1 for exactly the one following cycle.
- R3: An attempt that ends after fewer than `GLITCH_CYCLES` consecutive low samples never raises `wr_fire` or `wr_hold`.
- R4: `wr_hold` rises together with `wr_fire`. It stays 1 until the first edge at which the attempt is sampled ended, and it is 0 after that edge.
- R5: At any edge where `supply_ok` is sampled 0, no write is accepted, and a running `wr_hold` drops after that edge.
- R6: After `supply_ok` rises, the gate opens only at the (`HOLDOFF_CYCLES`+1)-th consecutive edge that samples it high, and it stays open while the flag stays high.
- R7: Each time `supply_ok` drops and rises again, even for a single cycle, the full hold-off restarts from zero.
- R8: When `oe_n` is sampled 0 at the accepting edge, the write is refused. When `oe_n` is sampled 0 during a running write, `wr_hold` drops after that edge.
- R9: A write attempt is judged once. If it is refused or cut off, it produces no `wr_fire` and no `wr_hold` for the rest of that low window, even if the gate reopens during the window.
- R10: Holding only one of `cs_n` or `we_n` low, for any length of time, starts no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Digital supply-good flag from the external comparator |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_fire | output | 1 | One-cycle start pulse for an accepted write |
| wr_hold | output | 1 | Qualified write level, high for the rest of an accepted window |

## Verification
The critical coincidence is the edge at which the glitch filter accepts an attempt landing on the very edge at which the supply hold-off expires. The bench lowers the supply flag for one cycle and raises it again. It then delays the start of the attempt so that the accepting edge falls one edge before the hold-off ends, or exactly on it. In the first case the attempt must be refused, and it must stay refused while the pins remain low. In the second case it must fire. The same kind of collision is provoked between acceptance and an output-enable change: the output-enable assertion is timed to land on the accepting edge and in the middle of a running write.

// File: rtl/wig_pkg.sv
package wig_pkg;

  // Next value of a saturating run counter. The counter is cleared when the
  // watched condition is absent, and otherwise climbs until it reaches lim.
  function automatic int unsigned run_next(input int unsigned cur,
                                           input int unsigned lim,
                                           input logic        present);
    if (!present)   return 0;
    if (cur < lim)  return cur + 1;
    return cur;
  endfunction

  // True on the sample at which a run reaches its required length.
  function automatic logic run_complete(input int unsigned cur,
                                        input int unsigned need,
                                        input logic        present);
    return present && (cur == need - 1);
  endfunction

endpackage

// File: rtl/wig_holdoff.sv
module wig_holdoff #(
  parameter int unsigned HOLDOFF_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic ready_o
);
  import wig_pkg::*;

  localparam int unsigned CW = $clog2(HOLDOFF_CYCLES + 1);

  logic [CW-1:0] good_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_cnt <= '0;
    else        good_cnt <= CW'(run_next(32'(good_cnt), HOLDOFF_CYCLES, supply_ok));
  end

  // Open only while the flag is high and the counter has seen enough prior edges.
  assign ready_o = supply_ok && (32'(good_cnt) == HOLDOFF_CYCLES);

  // R7: a fresh rise always begins closed
  p_rise_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_ok) |-> !ready_o);

  // R6: once open, stays open until the flag drops
  p_open_persists_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> (ready_o || !supply_ok));

endmodule

// File: rtl/wig_strobe_filter.sv
module wig_strobe_filter #(
  parameter int unsigned GLITCH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic we_n,
  output logic strobe_low_o,
  output logic accept_evt_o
);
  import wig_pkg::*;

  localparam int unsigned CW = $clog2(GLITCH_CYCLES + 1);

  logic [CW-1:0] low_cnt;

  assign strobe_low_o = !cs_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else        low_cnt <= CW'(run_next(32'(low_cnt), GLITCH_CYCLES, strobe_low_o));
  end

  // The edge at which the low run reaches its required length: exactly once per run.
  assign accept_evt_o = run_complete(32'(low_cnt), GLITCH_CYCLES, strobe_low_o);

  // R2: one acceptance per low window
  p_accept_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt_o |=> !accept_evt_o);

  generate
    if (GLITCH_CYCLES >= 2) begin : g_multi
      // R3: acceptance needs the strobe low on the previous edge too
      p_accept_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_evt_o |-> $past(strobe_low_o));
    end
  endgenerate

endmodule

// File: rtl/wig_qualify.sv
module wig_qualify (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_evt_i,
  input  logic strobe_low_i,
  input  logic allow_i,
  output logic fire_o,
  output logic hold_o
);
  logic fire_q, hold_q;
  logic start_now, keep_now;

  assign start_now = accept_evt_i && allow_i;
  assign keep_now  = hold_q && strobe_low_i && allow_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      fire_q <= start_now;
      hold_q <= start_now || keep_now;
    end
  end

  assign fire_o = fire_q;
  assign hold_o = hold_q;

  // R2: the start pulse lasts one cycle
  p_fire_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);

  // R4: the level comes up with the pulse
  p_fire_with_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> hold_q);

  // R9: a level that has dropped does not return without a new acceptance
  p_no_revive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !fire_q) |=> (!hold_q || fire_q));

endmodule

// File: rtl/write_inhibit_gate.sv
module write_inhibit_gate #(
  parameter int unsigned HOLDOFF_CYCLES = 500000,
  parameter int unsigned GLITCH_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_fire,
  output logic wr_hold
);
  logic supply_ready;
  logic strobe_low;
  logic accept_evt;
  logic gate_open;

  wig_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_holdoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .ready_o  (supply_ready)
  );

  wig_strobe_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .we_n        (we_n),
    .strobe_low_o(strobe_low),
    .accept_evt_o(accept_evt)
  );

  // Output enable asserted inhibits the write path outright.
  assign gate_open = supply_ready && oe_n;

  wig_qualify u_qualify (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_evt_i(accept_evt),
    .strobe_low_i(strobe_low),
    .allow_i     (gate_open),
    .fire_o      (wr_fire),
    .hold_o      (wr_hold)
  );

  // R5 / R8: a write level needs supply good and output enable released on the prior edge
  p_inhibits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |-> $past(supply_ok && oe_n));

  // R10: a write level needs both select lines low on the prior edge
  p_both_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |-> $past(!cs_n && !we_n));

  // R1: outputs quiet while reset is applied
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!wr_fire && !wr_hold));

endmodule

// File: tb/write_inhibit_gate_tb.sv
module write_inhibit_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 20;
  localparam int GL   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic cs_n = 1'b1;
  logic we_n = 1'b1;
  logic oe_n = 1'b1;
  logic wr_fire, wr_hold;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  write_inhibit_gate #(.HOLDOFF_CYCLES(HOLD), .GLITCH_CYCLES(GL)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .wr_fire(wr_fire), .wr_hold(wr_hold)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Supply low for a cycle, then high; settle past the hold-off.
  task automatic power_cycle_settle;
    supply_ok = 1'b0; tick(1);
    supply_ok = 1'b1; tick(HOLD + 4);
  endtask

  task automatic t_reset;
    tick(3);
    chk("R1 fire in reset", wr_fire, 1'b0);
    chk("R1 hold in reset", wr_hold, 1'b0);
    rst_n = 1'b1; tick(1);
    chk("R1 fire after reset", wr_fire, 1'b0);
    chk("R1 hold after reset", wr_hold, 1'b0);
  endtask

  task automatic t_supply_low_blocks;
    // R5: attempt with supply low the whole time
    cs_n = 1'b0; we_n = 1'b0;
    for (int i = 0; i < GL + 3; i++) begin
      tick(1);
      chk("R5 fire while supply low", wr_fire, 1'b0);
      chk("R5 hold while supply low", wr_hold, 1'b0);
    end
    cs_n = 1'b1; we_n = 1'b1; tick(1);
  endtask

  task automatic t_basic;
    power_cycle_settle();
    cs_n = 1'b0; we_n = 1'b0;
    tick(GL - 1);
    chk("R2 no fire before run length", wr_fire, 1'b0);
    tick(1);
    chk("R2 fire on accept", wr_fire, 1'b1);
    chk("R4 hold on accept", wr_hold, 1'b1);
    tick(1);
    chk("R2 fire one cycle", wr_fire, 1'b0);
    chk("R4 hold kept", wr_hold, 1'b1);
    tick(2);
    chk("R4 hold still kept", wr_hold, 1'b1);
    we_n = 1'b1; tick(1);
    chk("R4 hold ends with strobe", wr_hold, 1'b0);
    cs_n = 1'b1; tick(1);
  endtask

  task automatic t_glitch;
    for (int len = 1; len < GL; len++) begin
      cs_n = 1'b0; we_n = 1'b0;
      for (int i = 0; i < len; i++) begin
        tick(1);
        chk("R3 short pulse fire", wr_fire, 1'b0);
      end
      cs_n = 1'b1; we_n = 1'b1;
      tick(1);
      chk("R3 short pulse fire after", wr_fire, 1'b0);
      chk("R3 short pulse hold after", wr_hold, 1'b0);
    end
  endtask

  task automatic t_single_line;
    cs_n = 1'b0;
    tick(GL + 3);
    chk("R10 cs only fire", wr_fire, 1'b0);
    chk("R10 cs only hold", wr_hold, 1'b0);
    cs_n = 1'b1; we_n = 1'b0;
    tick(GL + 3);
    chk("R10 we only fire", wr_fire, 1'b0);
    chk("R10 we only hold", wr_hold, 1'b0);
    we_n = 1'b1; tick(1);
  endtask

  task automatic t_oe;
    // Output enable low at the accepting edge
    oe_n = 1'b0; cs_n = 1'b0; we_n = 1'b0;
    tick(GL);
    chk("R8 oe low refuses fire", wr_fire, 1'b0);
    chk("R8 oe low refuses hold", wr_hold, 1'b0);
    oe_n = 1'b1; tick(3);
    chk("R9 no fire after oe released", wr_fire, 1'b0);
    chk("R9 no hold after oe released", wr_hold, 1'b0);
    cs_n = 1'b1; we_n = 1'b1; tick(1);
    // Output enable asserted mid-write
    cs_n = 1'b0; we_n = 1'b0;
    tick(GL);
    chk("R2 fire before oe cut", wr_fire, 1'b1);
    tick(1);
    oe_n = 1'b0; tick(1);
    chk("R8 oe cuts hold", wr_hold, 1'b0);
    oe_n = 1'b1; tick(3);
    chk("R9 cut write not revived fire", wr_fire, 1'b0);
    chk("R9 cut write not revived hold", wr_hold, 1'b0);
    cs_n = 1'b1; we_n = 1'b1; tick(1);
  endtask

  task automatic t_supply_drop;
    cs_n = 1'b0; we_n = 1'b0;
    tick(GL + 1);
    chk("R4 hold before supply drop", wr_hold, 1'b1);
    supply_ok = 1'b0; tick(1);
    chk("R5 supply drop ends hold", wr_hold, 1'b0);
    supply_ok = 1'b1; tick(HOLD + 3);
    chk("R9 no revival after supply returns", wr_hold, 1'b0);
    cs_n = 1'b1; we_n = 1'b1; tick(1);
  endtask

  // The accepting edge lands one edge early or exactly on hold-off expiry.
  task automatic t_holdoff_edge(input int delay, input logic expect_fire);
    supply_ok = 1'b0; tick(1);
    supply_ok = 1'b1;
    tick(delay);
    cs_n = 1'b0; we_n = 1'b0;
    tick(GL);
    chk(expect_fire ? "R6 accept at hold-off expiry" : "R7 refuse before hold-off expiry",
        wr_fire, expect_fire);
    chk("R6 hold at boundary", wr_hold, expect_fire);
    tick(4);
    chk("R9 no late fire in window", wr_fire, 1'b0);
    chk("R9 level matches boundary decision", wr_hold, expect_fire);
    cs_n = 1'b1; we_n = 1'b1; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_supply_low_blocks();
    t_basic();
    t_glitch();
    t_single_line();
    t_oe();
    t_supply_drop();
    t_holdoff_edge(HOLD - GL, 1'b0);
    t_holdoff_edge(HOLD + 1 - GL, 1'b1);
    summary();
    $finish;
  end

endmodule